// File: doc/BRIEF.md
# Amplitude-Modulation Bit Encoder for Tag Emulation

This block turns a short stored bit sequence into the on/off level that drives a coil when a low-frequency tag is emulated. Bits are loaded into a small internal store through a single-bit write port. On a start request the block captures its configuration: the number of bits, the number of samples per bit, an invert flag and the coding mode. It then emits one output sample each time the field-clock strobe is high and repeats the sequence without end until a stop request.

Three codings are offered. Raw coding holds the bit for the whole bit period. Manchester coding sends the bit and then its complement. Biphase coding keeps a running phase that flips after every zero. In raw and biphase coding, a sequence whose first and last bits match would not join cleanly when it loops. For those sequences the block inserts a second pass over the bits before it starts again. In raw coding that second pass is complemented. In biphase coding it continues with the phase left by the first pass.

Top module: `ask_bit_encoder`

## Requirements
- R1: Every stored bit is XORed with the invert flag, captured at start, before any coding is applied.
- R2: Raw coding (mode 0) drives all samples of a bit period to the bit value.
- R3: In raw coding, when stored bit 0 equals stored bit len-1, each loop is the sequence followed by a second pass with every bit complemented.
- R4: Manchester coding (mode 1) drives the bit for the first clock/2 samples and its complement for the second clock/2 samples, and never inserts a second pass.
- R5: In biphase coding (mode 2), a 1 bit outputs the current phase for the first half and the inverse of the phase for the second half.
- R6: In biphase coding, a 0 bit outputs the current phase for the whole period and then inverts the phase. The phase is 0 at the start of every loop.
- R7: In biphase coding, when stored bit 0 equals stored bit len-1, the sequence is coded a second time with the phase carried over from the first pass.
- R8: Each bit takes exactly clock samples, and the loop repeats with no extra or missing samples. This includes a sequence of length 1.
- R9: A start is rejected when the clock value is odd or 0, the mode is 3, or the length is 0 or larger than the store. A rejected start sets cfg_err and leaves active low. A valid start clears cfg_err.
- R10: The coil level changes only on a cycle whose strobe is high while active. It holds otherwise.
- R11: Stop returns the block to idle within one cycle. While idle, coil is 0 and strobes have no effect.
- R12: After reset, coil, active and cfg_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one bit into the store |
| wr_addr | input | ADDR_W | Store address of the written bit |
| wr_bit | input | 1 | Bit value written |
| seq_len | input | ADDR_W+1 | Number of bits in the sequence, captured at start |
| bit_div | input | DIV_W | Samples per bit, even and at least 2, captured at start |
| enc_mode | input | 2 | 0 raw, 1 Manchester, 2 biphase, 3 invalid |
| invert | input | 1 | Invert all bits, captured at start |
| start | input | 1 | Capture configuration and begin encoding |
| stop | input | 1 | Return to idle; overrides start |
| strobe | input | 1 | Field-clock strobe, one output sample per high cycle |
| coil | output | 1 | Registered coil-control level |
| active | output | 1 | High while strobes are being consumed |
| cfg_err | output | 1 | Last start had an invalid configuration |

## Verification
The bench sweeps every mode against sequences whose end bits match and sequences whose end bits differ, at several clock values and both invert settings. It compares two or more complete loops with a waveform rebuilt arithmetically from the rules. A design that dropped or misplaced the fixup pass would go wrong at the loop seam: it would repeat the uncomplemented raw pass, or restart the biphase phase too early. A one-bit sequence stresses wrap-around with no distinct next bit. Irregular strobe gaps expose a coil that moves without a strobe. Odd clocks, mode 3 and a zero length must raise the error flag rather than run with a broken half period.

// File: rtl/ask_enc_pkg.sv
package ask_enc_pkg;
  typedef enum logic [1:0] {
    ENC_RAW   = 2'd0,
    ENC_MANCH = 2'd1,
    ENC_BIPH  = 2'd2,
    ENC_BAD   = 2'd3
  } enc_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PRIME0 = 3'd1,
    ST_PRIME1 = 3'd2,
    ST_PRIME2 = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_t;
endpackage

// File: rtl/ask_bit_store.sv
module ask_bit_store #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic mem [DEPTH];

  // registered read so the store maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_bit;
    rd_bit <= mem[rd_addr];
  end
endmodule

// File: rtl/ask_level_gen.sv
module ask_level_gen
  import ask_enc_pkg::*;
(
  input  enc_mode_t mode,
  input  logic      bit_v,
  input  logic      second_half,
  input  logic      fix_pass,
  input  logic      phase,
  output logic      level
);
  always_comb begin
    unique case (mode)
      ENC_RAW:   level = bit_v ^ fix_pass;
      ENC_MANCH: level = bit_v ^ second_half;
      ENC_BIPH:  level = bit_v ? (phase ^ second_half) : phase;
      default:   level = 1'b0;
    endcase
  end
endmodule

// File: rtl/ask_seq_ctrl.sv
module ask_seq_ctrl
  import ask_enc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              strobe,
  input  logic [1:0]        mode_in,
  input  logic              invert_in,
  input  logic [DIV_W-1:0]  div_in,
  input  logic [ADDR_W:0]   len_in,
  input  logic              rd_bit,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              run,
  output logic              err,
  output enc_mode_t         mode,
  output logic              bit_v,
  output logic              second_half,
  output logic              fix_pass,
  output logic              phase,
  output logic              half_mark
);
  localparam int LEN_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  seq_state_t        st_q;
  enc_mode_t         mode_q;
  logic              err_q, inv_q, pass_q, ph_q, cur_q, last_q, fix_q;
  logic [DIV_W-1:0]  div_q, half_q, cnt_q;
  logic [ADDR_W-1:0] lenm1_q, idx_q, nxt_idx;
  logic              cfg_bad, bit_end, ph_flip;

  always_comb begin
    cfg_bad = (mode_in == 2'd3) || div_in[0] || (div_in == '0) ||
              (len_in == '0) || (len_in > LEN_W'(DEPTH));
    nxt_idx = (idx_q == lenm1_q) ? '0 : idx_q + 1'b1;
    bit_end = (cnt_q == div_q - 1'b1);
    ph_flip = (mode_q == ENC_BIPH && !bit_v) ? ~ph_q : ph_q;
    unique case (st_q)
      ST_PRIME0: rd_addr = lenm1_q;
      ST_PRIME1: rd_addr = '0;
      default:   rd_addr = nxt_idx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; mode_q <= ENC_RAW; err_q <= 1'b0; inv_q <= 1'b0;
      div_q <= '0; half_q <= '0; cnt_q <= '0; lenm1_q <= '0; idx_q <= '0;
      pass_q <= 1'b0; ph_q <= 1'b0; cur_q <= 1'b0; last_q <= 1'b0; fix_q <= 1'b0;
    end else if (stop) begin
      st_q <= ST_IDLE;
    end else if (start) begin
      if (cfg_bad) begin
        err_q <= 1'b1;
        st_q  <= ST_IDLE;
      end else begin
        err_q   <= 1'b0;
        st_q    <= ST_PRIME0;
        mode_q  <= enc_mode_t'(mode_in);
        inv_q   <= invert_in;
        div_q   <= div_in;
        half_q  <= div_in >> 1;
        lenm1_q <= ADDR_W'(len_in - 1'b1);
        idx_q   <= '0;
        cnt_q   <= '0;
        pass_q  <= 1'b0;
        ph_q    <= 1'b0;
      end
    end else begin
      unique case (st_q)
        ST_PRIME0: st_q <= ST_PRIME1;
        ST_PRIME1: begin
          last_q <= rd_bit;
          st_q   <= ST_PRIME2;
        end
        ST_PRIME2: begin
          cur_q <= rd_bit;
          fix_q <= (rd_bit == last_q) && (mode_q != ENC_MANCH);
          st_q  <= ST_RUN;
        end
        ST_RUN: if (strobe) begin
          if (bit_end) begin
            cnt_q <= '0;
            cur_q <= rd_bit;
            if (idx_q == lenm1_q) begin
              idx_q <= '0;
              if (!pass_q && fix_q) begin
                pass_q <= 1'b1;
                ph_q   <= ph_flip;
              end else begin
                pass_q <= 1'b0;
                ph_q   <= 1'b0;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
              ph_q  <= ph_flip;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run         = (st_q == ST_RUN);
  assign err         = err_q;
  assign mode        = mode_q;
  assign bit_v       = cur_q ^ inv_q;
  assign second_half = (cnt_q >= half_q);
  assign fix_pass    = pass_q;
  assign phase       = ph_q;
  assign half_mark   = (cnt_q == half_q);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt_q < div_q); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> idx_q <= lenm1_q); // R8
  AST_ERR_NOT_RUN: assert property (@(posedge clk) disable iff (rst)
    err |-> !run); // R9
  AST_PHASE_LOOP: assert property (@(posedge clk) disable iff (rst)
    (run && mode_q == ENC_BIPH && !pass_q && idx_q == '0 && cnt_q == '0) |-> !ph_q); // R6
  AST_MANCH_NOFIX: assert property (@(posedge clk) disable iff (rst)
    (run && mode_q == ENC_MANCH) |-> !pass_q); // R4
endmodule

// File: rtl/ask_bit_encoder.sv
module ask_bit_encoder
  import ask_enc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic [ADDR_W:0]   seq_len,
  input  logic [DIV_W-1:0]  bit_div,
  input  logic [1:0]        enc_mode,
  input  logic              invert,
  input  logic              start,
  input  logic              stop,
  input  logic              strobe,
  output logic              coil,
  output logic              active,
  output logic              cfg_err
);
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_bit, run, bit_v, second_half, fix_pass, phase, level, half_mark;
  enc_mode_t         mode;
  logic              coil_q;

  ask_bit_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .rd_addr(rd_addr), .rd_bit(rd_bit)
  );

  ask_seq_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .strobe(strobe),
    .mode_in(enc_mode), .invert_in(invert), .div_in(bit_div), .len_in(seq_len),
    .rd_bit(rd_bit), .rd_addr(rd_addr), .run(run), .err(cfg_err), .mode(mode),
    .bit_v(bit_v), .second_half(second_half), .fix_pass(fix_pass),
    .phase(phase), .half_mark(half_mark)
  );

  ask_level_gen u_level (
    .mode(mode), .bit_v(bit_v), .second_half(second_half),
    .fix_pass(fix_pass), .phase(phase), .level(level)
  );

  always_ff @(posedge clk) begin
    if (rst || start || stop || !run) coil_q <= 1'b0;
    else if (strobe)                  coil_q <= level;
  end

  assign coil   = coil_q;
  assign active = run;

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !run |=> !coil); // R11
  AST_COIL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run && !strobe && !start && !stop) |=> $stable(coil)); // R10
  AST_MANCH_FLIP: assert property (@(posedge clk) disable iff (rst)
    (run && strobe && !start && !stop && mode == ENC_MANCH && half_mark)
    |=> coil != $past(coil)); // R4
endmodule

// File: tb/ask_bit_encoder_tb.sv
module ask_bit_encoder_tb;
  localparam int ADDR_W = 4;
  localparam int DIV_W  = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, wr_bit = 1'b0, invert = 1'b0, start = 1'b0, stop = 1'b0, strobe = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [ADDR_W:0]   seq_len = '0;
  logic [DIV_W-1:0]  bit_div = '0;
  logic [1:0]        enc_mode = '0;
  logic coil, active, cfg_err;

  int n_chk = 0, n_bad = 0;
  logic exp_s [512];
  int   exp_n;

  always #2 clk = ~clk;

  ask_bit_encoder #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .seq_len(seq_len), .bit_div(bit_div), .enc_mode(enc_mode), .invert(invert),
    .start(start), .stop(stop), .strobe(strobe),
    .coil(coil), .active(active), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // expected loop waveform built from the coding rules
  task automatic build(input int mode, input logic inv, input int div, input int len,
                       input logic [15:0] pat);
    int passes;
    logic ph;
    exp_n = 0;
    ph = 1'b0;
    passes = ((pat[0] == pat[len-1]) && mode != 1) ? 2 : 1;
    for (int p = 0; p < passes; p++) begin
      for (int i = 0; i < len; i++) begin
        logic b;
        b = pat[i] ^ inv;
        for (int k = 0; k < div; k++) begin
          logic h;
          h = (k >= div/2);
          if (mode == 0)      exp_s[exp_n] = b ^ (p == 1);
          else if (mode == 1) exp_s[exp_n] = b ^ h;
          else                exp_s[exp_n] = b ? (ph ^ h) : ph;
          exp_n++;
        end
        if (mode == 2 && !b) ph = ~ph;
      end
    end
  endtask

  task automatic load(input int len, input logic [15:0] pat);
    for (int i = 0; i < len; i++) begin
      wr_en = 1'b1; wr_addr = ADDR_W'(i); wr_bit = pat[i];
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic kick(input int mode, input logic inv, input int div, input int len);
    enc_mode = 2'(mode); invert = inv; bit_div = DIV_W'(div); seq_len = (ADDR_W+1)'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 8 && !active; t++) @(negedge clk);
  endtask

  task automatic stream(input string tag, input bit gaps);
    logic prev;
    prev = coil;
    for (int s = 0; s < 2*exp_n + 3; s++) begin
      if (gaps && (s % 3 == 1)) begin
        strobe = 1'b0;
        @(negedge clk);
        chk("R10", coil, prev);
      end
      strobe = 1'b1;
      @(negedge clk);
      chk(tag, coil, exp_s[s % exp_n]);
      prev = coil;
    end
    strobe = 1'b0;
  endtask

  task automatic halt();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  function automatic string tag_of(int mode, logic inv, int len, logic [15:0] pat);
    logic eq;
    eq = (pat[0] == pat[len-1]);
    if (len == 1) return "R8";
    if (inv)      return "R1";
    if (mode == 0) return eq ? "R3" : "R2";
    if (mode == 1) return "R4";
    if (eq)        return "R7";
    return pat[1] ? "R5" : "R6";
  endfunction

  logic [15:0] pats [4];
  int          lens [4];

  initial begin
    pats[0] = 16'hA5C3; lens[0] = 16;
    pats[1] = 16'h00F2; lens[1] = 9;
    pats[2] = 16'h0B36; lens[2] = 12;
    pats[3] = 16'h0001; lens[3] = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", coil, 1'b0);
    chk("R12", active, 1'b0);
    chk("R12", cfg_err, 1'b0);

    // strobes while idle do nothing
    strobe = 1'b1;
    repeat (3) @(negedge clk);
    strobe = 1'b0;
    chk("R11", coil, 1'b0);

    for (int m = 0; m < 3; m++)
      for (int pi = 0; pi < 4; pi++)
        for (int d = 2; d <= 6; d += 2)
          for (int iv = 0; iv < 2; iv++) begin
            load(lens[pi], pats[pi]);
            build(m, iv[0], d, lens[pi], pats[pi]);
            kick(m, iv[0], d, lens[pi]);
            chk("R8", active, 1'b1);
            stream(tag_of(m, iv[0], lens[pi], pats[pi]), 1'b0);
            halt();
          end

    // strobe gaps: biphase with fixup, then Manchester
    load(9, 16'h00F2);
    build(2, 1'b0, 4, 9, 16'h00F2);
    kick(2, 1'b0, 4, 9);
    stream("R7", 1'b1);
    build(1, 1'b1, 2, 9, 16'h00F2);
    kick(1, 1'b1, 2, 9);
    stream("R4", 1'b1);

    // stop mid-stream
    strobe = 1'b1;
    repeat (5) @(negedge clk);
    strobe = 1'b0;
    halt();
    chk("R11", coil, 1'b0);
    chk("R11", active, 1'b0);

    // invalid configurations
    kick(0, 1'b0, 3, 9);
    chk("R9", cfg_err, 1'b1);
    chk("R9", active, 1'b0);
    kick(3, 1'b0, 4, 9);
    chk("R9", cfg_err, 1'b1);
    chk("R9", active, 1'b0);
    kick(0, 1'b0, 4, 0);
    chk("R9", cfg_err, 1'b1);
    kick(1, 1'b0, 0, 9);
    chk("R9", cfg_err, 1'b1);
    kick(0, 1'b0, 4, 17);
    chk("R9", cfg_err, 1'b1);
    chk("R9", active, 1'b0);
    kick(0, 1'b0, 4, 9);
    chk("R9", cfg_err, 1'b0);
    chk("R9", active, 1'b1);
    halt();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule